// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Divide-by-Eight Clock Divider

This block divides an input clock by eight with a four-stage twisted-ring shift register. Every stage is clocked by the same input clock. Each stage takes the value of the stage before it, and the first stage takes the inverse of the last stage. The register therefore walks through a cycle of eight codes, and only one bit changes on each step. Every stage output is a 50% duty clock at one eighth of the input rate. Each stage lags the stage before it by one input clock, so the four outputs are four phases of the same divided clock.

Two named classes drive the next-state logic. In `ST_LEGAL` the register is on the eight-code cycle and shifts as described. In `ST_ILLEGAL` it holds one of the eight codes that a plain twisted ring can circulate in forever, and the next enabled clock sends it to all zeros. The named transitions are *shift* (legal, enabled), *recover* (illegal, enabled, goes to 0000), *hold* (enable low) and *clear* (reset, goes to 0000). A two-bit phase select picks which stage drives the single divided-clock output.

Top module: `jdiv8_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register becomes 0000 on that edge, whatever `clk_en` is.
- R2: With `clk_en` high and starting from reset, `stage_clk` written as Q1Q2Q3Q4 (Q1 is `stage_clk[0]`) goes 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001 and then repeats from 0000.
- R3: Under continuous enable, each stage output is high for four input clocks and then low for four input clocks.
- R4: On every enabled clock from a legal code, exactly one bit of `stage_clk` changes.
- R5: While `clk_en` is low and `rst` is low, `stage_clk` keeps its value on every edge, and this includes illegal codes.
- R6: Any of the eight illegal codes (as Q1Q2Q3Q4: 0010, 0100, 0101, 0110, 1001, 1010, 1011, 1101) becomes 0000 on the next enabled clock, and the cycle of R2 then carries on.
- R7: `div_clk` equals `stage_clk[phase_sel]`, and stage k (counting from 0) is stage 0 delayed by k input clocks.
- R8: The divide ratio is twice the number of stages, so the sequence repeats every 8 enabled clocks with the default of four stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that all stages share |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Step enable; the register holds while this is low |
| phase_sel | input | 2 | Picks which stage drives `div_clk` |
| stage_clk | output | 4 | Stage outputs, bit 0 is the first stage |
| div_clk | output | 1 | Selected divided clock |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that an illegal code only gets into the register from outside, so the single-bit-change check only applies from legal codes, and the hold check only applies after an edge where the enable was low. The bench loads each illegal code directly into the state register between edges. Before each load it drives `clk_en` high for one edge, so the hold check never compares across a load. After the load it lets the register recover or hold. Random enable and phase-select patterns from a fixed seed then run the normal cycle.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;
    typedef enum logic {
        ST_LEGAL   = 1'b0,
        ST_ILLEGAL = 1'b1
    } jdiv_class_e;
endpackage

// File: rtl/jdiv_classify.sv
module jdiv_classify
    import jdiv_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic [STAGES-1:0] q,
    output jdiv_class_e       cls
);
    logic [$clog2(STAGES+1)-1:0] edges;

    // A code is on the twisted-ring cycle when neighbouring stages differ at most once.
    always_comb begin
        edges = '0;
        for (int i = 0; i < STAGES-1; i++) begin
            if (q[i] != q[i+1]) edges = edges + 1'b1;
        end
        cls = (edges <= 1) ? ST_LEGAL : ST_ILLEGAL;
    end
endmodule

// File: rtl/jdiv_next.sv
module jdiv_next
    import jdiv_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  jdiv_class_e       cls,
    input  logic [STAGES-1:0] q,
    output logic [STAGES-1:0] d
);
    always_comb begin
        if (!en) begin
            d = q;
        end else begin
            unique case (cls)
                ST_LEGAL:   d = {q[STAGES-2:0], ~q[STAGES-1]};
                ST_ILLEGAL: d = '0;
                default:    d = '0;
            endcase
        end
    end

    // R4: a shift from a legal code flips exactly one stage
    a_r4_one_bit: assert property (@(posedge clk) disable iff (rst)
        (en && cls == ST_LEGAL) |-> ($countones(d ^ q) == 1));

    // R6: an illegal code is cleared by the next enabled edge
    a_r6_recover: assert property (@(posedge clk) disable iff (rst)
        (en && cls == ST_ILLEGAL) |-> (d == '0));
endmodule

// File: rtl/jdiv_ring_reg.sv
module jdiv_ring_reg #(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] d,
    output logic [STAGES-1:0] q
);
    logic [STAGES-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= d;
    end

    assign q = q_r;

    // R1: reset clears every stage on the same edge
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (q == '0));
endmodule

// File: rtl/jdiv_phase_mux.sv
module jdiv_phase_mux #(
    parameter int STAGES = 4,
    parameter int SEL_W  = 2
) (
    input  logic [STAGES-1:0] phases,
    input  logic [SEL_W-1:0]  sel,
    output logic              y
);
    always_comb begin
        y = phases[0];
        for (int k = 0; k < STAGES; k++) begin
            if (sel == SEL_W'(k)) y = phases[k];
        end
    end
endmodule

// File: rtl/jdiv8_top.sv
module jdiv8_top
    import jdiv_pkg::*;
#(
    parameter int STAGES = 4,
    parameter int SEL_W  = $clog2(STAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic [SEL_W-1:0]  phase_sel,
    output logic [STAGES-1:0] stage_clk,
    output logic              div_clk
);
    localparam int RATIO = 2 * STAGES;

    jdiv_class_e       cls;
    logic [STAGES-1:0] q;
    logic [STAGES-1:0] d;

    jdiv_classify #(.STAGES(STAGES)) u_cls (.q(q), .cls(cls));

    jdiv_next #(.STAGES(STAGES)) u_next (
        .clk(clk), .rst(rst), .en(clk_en), .cls(cls), .q(q), .d(d)
    );

    jdiv_ring_reg #(.STAGES(STAGES)) u_reg (
        .clk(clk), .rst(rst), .d(d), .q(q)
    );

    jdiv_phase_mux #(.STAGES(STAGES), .SEL_W(SEL_W)) u_mux (
        .phases(q), .sel(phase_sel), .y(div_clk)
    );

    assign stage_clk = q;

    // R5: a low enable freezes the register
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(stage_clk));

    // R8: the ratio parameter stays tied to the stage count
    initial a_r8_ratio: assert (RATIO == 2 * STAGES && RATIO >= 4);
endmodule

// File: tb/tb_jdiv8_top.sv
module tb_jdiv8_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b0;
    logic [1:0] phase_sel = 2'd0;
    logic [3:0] stage_clk;
    logic       div_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [3:0] exp_q = 4'b0000;

    jdiv8_top dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .phase_sel(phase_sel),
        .stage_clk(stage_clk), .div_clk(div_clk)
    );

    always #10 clk = ~clk;

    // Q1Q2Q3Q4 string (Q1 as MSB) to port vector (Q1 in bit 0)
    function automatic logic [3:0] vec(input logic [3:0] q1234);
        return {q1234[0], q1234[1], q1234[2], q1234[3]};
    endfunction

    function automatic logic [3:0] seq_at(input int i);
        logic [3:0] t [8] = '{4'b0000, 4'b1000, 4'b1100, 4'b1110,
                              4'b1111, 4'b0111, 4'b0011, 4'b0001};
        return vec(t[i % 8]);
    endfunction

    function automatic logic [3:0] model(input logic [3:0] q, input logic r, input logic e);
        if (r) return 4'b0000;
        if (!e) return q;
        for (int i = 0; i < 8; i++) if (seq_at(i) == q) return seq_at(i + 1);
        return 4'b0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        exp_q = model(exp_q, rst, clk_en);
        @(negedge clk);
        #1;
    endtask

    task automatic check_ports(input string req);
        chk(stage_clk == exp_q, req, stage_clk, exp_q);
        chk(div_clk == exp_q[phase_sel], {req, " R7 div_clk"}, {3'b0, div_clk}, {3'b0, exp_q[phase_sel]});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [3:0] illegal [8] = '{4'b0010, 4'b0100, 4'b0101, 4'b0110,
                                   4'b1001, 4'b1010, 4'b1011, 4'b1101};
        logic [3:0] prev;
        logic [3:0] code;
        int highs [4];
        void'($urandom(32'd2024));

        // R1: reset state, with enable high as well
        clk_en = 1'b1;
        step(); step();
        chk(stage_clk == 4'b0000, "R1 reset", stage_clk, 4'b0000);
        rst = 1'b0;

        // R2, R3, R7, R8: sixteen enabled clocks from reset
        for (int s = 0; s < 4; s++) highs[s] = 0;
        for (int t = 1; t <= 16; t++) begin
            prev = stage_clk;
            phase_sel = 2'(t);
            step();
            chk(stage_clk == seq_at(t), "R2 R8 sequence", stage_clk, seq_at(t));
            chk($countones(stage_clk ^ prev) == 1, "R4 one bit", stage_clk ^ prev, 4'b0001);
            check_ports("R7");
            for (int k = 0; k < 4; k++) begin
                logic want;
                want = (((t - k + 8) % 8) >= 1) && (((t - k + 8) % 8) <= 4);
                chk(stage_clk[k] == want, "R3 R7 duty/lag", {3'b0, stage_clk[k]}, {3'b0, want});
                if (t <= 8 && stage_clk[k]) highs[k]++;
            end
        end
        for (int k = 0; k < 4; k++)
            chk(highs[k] == 4, "R3 four high", 4'(highs[k]), 4'd4);

        // R5: hold in a legal state
        clk_en = 1'b0;
        prev = stage_clk;
        for (int t = 0; t < 5; t++) begin
            step();
            chk(stage_clk == prev, "R5 hold", stage_clk, prev);
        end
        clk_en = 1'b1;

        // R6: recovery from each illegal code
        for (int i = 0; i < 8; i++) begin
            code = vec(illegal[i]);
            clk_en = 1'b1;
            step();
            force dut.u_reg.q_r = code;
            #1;
            release dut.u_reg.q_r;
            exp_q = code;
            chk(stage_clk == code, "R6 loaded", stage_clk, code);
            if (i == 3) begin
                // R5: an illegal code also holds while disabled
                clk_en = 1'b0;
                step(); step();
                chk(stage_clk == code, "R5 hold illegal", stage_clk, code);
                clk_en = 1'b1;
            end
            step();
            chk(stage_clk == 4'b0000, "R6 recover", stage_clk, 4'b0000);
            step();
            chk(stage_clk == vec(4'b1000), "R6 rejoin", stage_clk, vec(4'b1000));
        end

        // Random enable and phase select against the model
        for (int t = 0; t < 400; t++) begin
            clk_en = ($urandom % 4) != 0;
            phase_sel = 2'($urandom % 4);
            rst = ($urandom % 50) == 0;
            step();
            check_ports(rst ? "R1 random" : "R2 R5 random");
        end
        rst = 1'b0;
        finish_run();
    end
endmodule